// File: doc/BRIEF.md
# TDM Bus Time-Slot Engine

This block is the clock master of a four-wire time-division serial bus. It produces the bit clock, the frame sync and the serial output, and it samples the serial input. A frame has a programmable number of bits. Its duration is that bit count times two half-periods of the divided system clock. Chosen to suit the system clock, this gives the usual 8 kHz frame rate. A few independent slots sit inside the frame. Each slot has its own first bit position, length, direction, bit order and inversion.

A transmit slot serialises the low-order bits of a 32-bit word held in a register. A receive slot collects bits back into the low-order end of a 32-bit word. The receive word is published only when it differs from the last published value. Optionally it is published only after the same new value has arrived in two consecutive frames. All settings are loaded through a plain register write port into shadow copies. The shadow copies become live together at the next frame boundary.

Top module: `tdm_slot_engine`

## Requirements
- R1: `tdm_clk` is high for HALF_DIV system cycles and then low for HALF_DIV system cycles. A frame lasts bpf bits, so frame sync rises every bpf*2*HALF_DIV cycles. bpf is global register (address 0) bits [15:0]; bit 16 is the transmit enable and bit 17 the receive enable.
- R2: `tdm_fs` is high for exactly the first bit of each frame. `tdm_fs` and `tdm_dout` change only at the system edge where `tdm_clk` rises.
- R3: `tdm_din` is sampled at the system edge where `tdm_clk` falls, in the middle of each bit.
- R4: Slot i is configured at address 2i+1 and its word is at address 2i+2. The configuration fields are: bit 0 enable, bit 1 transmit (0 = receive), bit 2 MSB-first, bit 3 invert, bit 4 two-frame confirm, bits [13:8] length (1 to 32), bits [31:16] first bit. A transmit slot drives frame bits first..first+len-1 from word bits [len-1:0]. It starts with bit len-1 when MSB-first, otherwise with bit 0. A first bit of 0 places the slot under the frame sync bit.
- R5: The invert flag complements every bit a slot drives onto, or takes from, the wire.
- R6: `tdm_dout` is 1 in every bit not covered by an enabled transmit slot, and in every bit while the transmit enable is 0.
- R7: A receive slot assembles its bits into bits [len-1:0] of a word, with bits above len cleared. The first wire bit becomes bit len-1 when MSB-first, otherwise bit 0.
- R8: At the end of a receive slot, a word that differs from the published `rx_word` replaces it. In the same cycle `rx_event` pulses for one system cycle. An unchanged word causes neither.
- R9: With two-frame confirm set, a new word is published, and the event raised, only when it equals the word received by that slot in the previous frame.
- R10: While the receive enable is 0, no input is taken and `rx_word` and `rx_event` stay unchanged.
- R11: Writes go to shadow registers. They take effect together at the start of the next frame, so a frame already under way keeps its old settings.
- R12: During reset, `tdm_clk` and `tdm_fs` are 0, `tdm_dout` is 1, and all `rx_word` and `rx_event` bits are 0. After reset, bpf is DEF_BPF and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | 32 | Register write data |
| tdm_clk | output | 1 | Bus bit clock |
| tdm_fs | output | 1 | Frame sync, high during bit 0 |
| tdm_dout | output | 1 | Serial output highway |
| tdm_din | input | 1 | Serial input highway |
| rx_word | output | NSLOT*32 | Published receive word per slot, slot i at [32i+31:32i] |
| rx_event | output | NSLOT | One-cycle pulse per slot when its word is republished |

## Verification
Transmit frames are captured bit by bit at the rising bus clock and compared in full with frames built from the requirements. These frames cover an MSB-first byte, an inverted LSB-first 12-bit slot, a slot starting under the frame sync and a full 32-bit slot. Between them they separate bit-order mistakes, inversion mistakes, off-by-one placement and wrong idle level. A word rewritten in the middle of a frame separates shadowed loading from immediate loading. Receive patterns are driven just after each rising edge, so sampling on the wrong edge shifts the word. Repeated, changed and once-only values tell the plain change report apart from the two-frame confirm mode and from the disabled input highway.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 6;
    localparam int POS_W  = 16;

    typedef struct packed {
        logic [POS_W-1:0] start;
        logic [LEN_W-1:0] len;
        logic             need_two;
        logic             invert;
        logic             msb_first;
        logic             is_tx;
        logic             en;
    } slot_cfg_t;

    typedef struct packed {
        logic             rx_en;
        logic             tx_en;
        logic [POS_W-1:0] bpf;
    } glb_cfg_t;

    function automatic logic in_window(logic [POS_W-1:0] pos,
                                       logic [POS_W-1:0] start,
                                       logic [LEN_W-1:0] len);
        logic [POS_W:0] lo;
        logic [POS_W:0] hi;
        lo = {1'b0, start};
        hi = lo + (POS_W+1)'(len);
        return ({1'b0, pos} >= lo) && ({1'b0, pos} < hi);
    endfunction

endpackage

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
    import tdm_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] bpf,
    output logic             rise_tick,
    output logic             fall_tick,
    output logic             frame_start,
    output logic [POS_W-1:0] nxt_bit,
    output logic [POS_W-1:0] cur_bit,
    output logic             bit_clk
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int DIV_W  = $clog2(PERIOD);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PERIOD - 1);
    localparam logic [DIV_W-1:0] DIV_FALL = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [POS_W-1:0] bitn;
        logic             bclk;
    } st_t;

    st_t  st_d, st_q;
    logic wrap;

    always_comb begin
        st_d      = st_q;
        rise_tick = (st_q.div == DIV_LAST);
        fall_tick = (st_q.div == DIV_FALL);
        wrap      = (({1'b0, st_q.bitn} + (POS_W+1)'(1)) >= {1'b0, bpf});
        nxt_bit   = wrap ? '0 : st_q.bitn + POS_W'(1);
        frame_start = rise_tick && wrap;
        if (rise_tick) begin
            st_d.div  = '0;
            st_d.bitn = nxt_bit;
            st_d.bclk = 1'b1;
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
            if (fall_tick) st_d.bclk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div  <= DIV_LAST;
            st_q.bitn <= '1;
            st_q.bclk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_bit = st_q.bitn;
    assign bit_clk = st_q.bclk;

    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (cur_bit == '0));

endmodule

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
    import tdm_pkg::*;
#(
    parameter int NSLOT   = 4,
    parameter int AW      = 4,
    parameter int DEF_BPF = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic                          frame_start,
    output logic [POS_W-1:0]              act_bpf,
    output logic                          nxt_tx_en,
    output logic                          nxt_rx_en,
    output slot_cfg_t [NSLOT-1:0]         nxt_cfg,
    output logic [NSLOT-1:0][WORD_W-1:0]  nxt_word
);
    typedef struct packed {
        glb_cfg_t                        sh_g;
        glb_cfg_t                        act_g;
        slot_cfg_t [NSLOT-1:0]           sh_c;
        slot_cfg_t [NSLOT-1:0]           act_c;
        logic [NSLOT-1:0][WORD_W-1:0]    sh_w;
        logic [NSLOT-1:0][WORD_W-1:0]    act_w;
    } st_t;

    st_t       st_d, st_q;
    slot_cfg_t wr_cfg;
    glb_cfg_t  wr_glb;

    always_comb begin
        wr_cfg.start     = wr_data[31:16];
        wr_cfg.len       = wr_data[13:8];
        wr_cfg.need_two  = wr_data[4];
        wr_cfg.invert    = wr_data[3];
        wr_cfg.msb_first = wr_data[2];
        wr_cfg.is_tx     = wr_data[1];
        wr_cfg.en        = wr_data[0];
        wr_glb.bpf       = wr_data[15:0];
        wr_glb.tx_en     = wr_data[16];
        wr_glb.rx_en     = wr_data[17];
    end

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.act_g = st_q.sh_g;
            st_d.act_c = st_q.sh_c;
            st_d.act_w = st_q.sh_w;
        end
        if (wr_en) begin
            if (wr_addr == '0) st_d.sh_g = wr_glb;
            for (int i = 0; i < NSLOT; i++) begin
                if (wr_addr == AW'(2*i + 1)) st_d.sh_c[i] = wr_cfg;
                if (wr_addr == AW'(2*i + 2)) st_d.sh_w[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sh_g.bpf  <= POS_W'(DEF_BPF);
            st_q.act_g.bpf <= POS_W'(DEF_BPF);
        end else begin
            st_q <= st_d;
        end
    end

    assign act_bpf   = st_q.act_g.bpf;
    assign nxt_tx_en = frame_start ? st_q.sh_g.tx_en : st_q.act_g.tx_en;
    assign nxt_rx_en = frame_start ? st_q.sh_g.rx_en : st_q.act_g.rx_en;
    assign nxt_cfg   = frame_start ? st_q.sh_c : st_q.act_c;
    assign nxt_word  = frame_start ? st_q.sh_w : st_q.act_w;

    p_apply_at_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.act_w) || !$stable(st_q.act_c)) |-> $past(frame_start));

endmodule

// File: rtl/tdm_slot.sv
module tdm_slot
    import tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_cfg_t         cfg,
    input  logic [WORD_W-1:0] word,
    input  logic [POS_W-1:0]  nxt_bit,
    input  logic [POS_W-1:0]  cur_bit,
    input  logic              fall_tick,
    input  logic              rx_en,
    input  logic              din,
    output logic              tx_hit,
    output logic              tx_bit,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_event
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] held;
        logic [WORD_W-1:0] cand;
        logic              ev;
    } st_t;

    st_t               st_d, st_q;
    logic [LEN_W-1:0]  tx_k, tx_idx, rx_k;
    logic [WORD_W-1:0] base, nacc;
    logic              rx_b;

    always_comb begin
        tx_k   = LEN_W'(nxt_bit - cfg.start);
        tx_idx = cfg.msb_first ? (cfg.len - LEN_W'(1) - tx_k) : tx_k;
        tx_hit = cfg.en && cfg.is_tx && in_window(nxt_bit, cfg.start, cfg.len);
        tx_bit = (|(word & (WORD_W'(1) << tx_idx))) ^ cfg.invert;
    end

    always_comb begin
        st_d    = st_q;
        st_d.ev = 1'b0;
        rx_k    = LEN_W'(cur_bit - cfg.start);
        rx_b    = din ^ cfg.invert;
        base    = (rx_k == '0) ? '0 : st_q.acc;
        nacc    = cfg.msb_first ? {base[WORD_W-2:0], rx_b}
                                : (base | (WORD_W'(rx_b) << rx_k));
        if (fall_tick && rx_en && cfg.en && !cfg.is_tx &&
            in_window(cur_bit, cfg.start, cfg.len)) begin
            st_d.acc = nacc;
            if (rx_k == cfg.len - LEN_W'(1)) begin
                if (cfg.need_two) begin
                    if (nacc == st_q.cand && nacc != st_q.held) begin
                        st_d.held = nacc;
                        st_d.ev   = 1'b1;
                    end
                end else if (nacc != st_q.held) begin
                    st_d.held = nacc;
                    st_d.ev   = 1'b1;
                end
                st_d.cand = nacc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_word  = st_q.held;
    assign rx_event = st_q.ev;

    p_event_changes_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> !$stable(rx_word));

    p_sample_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> $past(fall_tick));

endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine
    import tdm_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int HALF_DIV = 2,
    parameter int DEF_BPF  = 64,
    localparam int AW      = $clog2(2*NSLOT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [31:0]               wr_data,
    output logic                      tdm_clk,
    output logic                      tdm_fs,
    output logic                      tdm_dout,
    input  logic                      tdm_din,
    output logic [NSLOT*32-1:0]       rx_word,
    output logic [NSLOT-1:0]          rx_event
);
    typedef struct packed {
        logic dout;
        logic fs;
    } st_t;

    st_t                          st_d, st_q;
    logic                         rise_tick, fall_tick, frame_start;
    logic [POS_W-1:0]             nxt_bit, cur_bit, act_bpf;
    logic                         nxt_tx_en, nxt_rx_en;
    slot_cfg_t [NSLOT-1:0]        nxt_cfg;
    logic [NSLOT-1:0][WORD_W-1:0] nxt_word;
    logic [NSLOT-1:0]             hit, tbit;

    tdm_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .bpf(act_bpf),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .frame_start(frame_start),
        .nxt_bit(nxt_bit), .cur_bit(cur_bit), .bit_clk(tdm_clk)
    );

    tdm_cfg_regs #(.NSLOT(NSLOT), .AW(AW), .DEF_BPF(DEF_BPF)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start), .act_bpf(act_bpf),
        .nxt_tx_en(nxt_tx_en), .nxt_rx_en(nxt_rx_en),
        .nxt_cfg(nxt_cfg), .nxt_word(nxt_word)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        tdm_slot u_slot (
            .clk(clk), .rst_n(rst_n), .cfg(nxt_cfg[g]), .word(nxt_word[g]),
            .nxt_bit(nxt_bit), .cur_bit(cur_bit), .fall_tick(fall_tick),
            .rx_en(nxt_rx_en), .din(tdm_din),
            .tx_hit(hit[g]), .tx_bit(tbit[g]),
            .rx_word(rx_word[g*WORD_W +: WORD_W]), .rx_event(rx_event[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (rise_tick) begin
            st_d.fs   = (nxt_bit == '0);
            st_d.dout = (nxt_tx_en && (|hit)) ? (|(hit & tbit)) : 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dout <= 1'b1;
            st_q.fs   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tdm_dout = st_q.dout;
    assign tdm_fs   = st_q.fs;

    p_fs_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdm_fs) |-> $rose(tdm_clk));

    p_dout_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdm_dout) |-> $rose(tdm_clk));

    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_tick && !nxt_tx_en) |=> tdm_dout);

endmodule

// File: tb/tdm_slot_engine_tb.sv
module tdm_slot_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 4;
    localparam int HALF  = 2;
    localparam int AW    = 4;
    localparam int WD    = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic tdm_clk, tdm_fs, tdm_dout;
    logic tdm_din = 1'b1;
    logic [NSLOT*32-1:0] rx_word;
    logic [NSLOT-1:0] rx_event;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, fs_cnt = 0, fs_cyc = 0, fs_per = 0, idx = 0;
    int clk_run = 0, hi_w = 0, fs_run = 0, fs_w = 0;
    int ev_cnt [NSLOT];
    logic clk_prev = 1'b0;
    logic cur [256];
    logic lastf [256];
    logic expf [256];
    logic din_pat [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_engine #(.NSLOT(NSLOT), .HALF_DIV(HALF), .DEF_BPF(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tdm_clk(tdm_clk), .tdm_fs(tdm_fs), .tdm_dout(tdm_dout), .tdm_din(tdm_din),
        .rx_word(rx_word), .rx_event(rx_event)
    );

    initial begin
        for (int i = 0; i < NSLOT; i++) ev_cnt[i] = 0;
        for (int i = 0; i < 256; i++) begin
            cur[i] = 1'b1; lastf[i] = 1'b1; din_pat[i] = 1'b1;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (tdm_fs) fs_run++;
            else if (fs_run != 0) begin fs_w = fs_run; fs_run = 0; end
            if (tdm_clk) clk_run++;
            else if (clk_run != 0) begin hi_w = clk_run; clk_run = 0; end
            if (tdm_clk && !clk_prev) begin
                if (tdm_fs) begin
                    lastf = cur;
                    fs_cnt++;
                    fs_per = cyc - fs_cyc;
                    fs_cyc = cyc;
                    idx = 0;
                end else begin
                    idx++;
                end
                if (idx < 256) begin
                    cur[idx] = tdm_dout;
                    tdm_din  = din_pat[idx];
                end
            end
            for (int i = 0; i < NSLOT; i++) if (rx_event[i]) ev_cnt[i]++;
        end
        clk_prev = tdm_clk;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_frame(string tag, int bpf);
        int bad_at = -1;
        n_chk++;
        for (int i = 0; i < bpf; i++) if (lastf[i] !== expf[i] && bad_at < 0) bad_at = i;
        if (bad_at >= 0) begin
            n_bad++;
            $display("FAIL %s bit %0d actual=%b expected=%b", tag, bad_at, lastf[bad_at], expf[bad_at]);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_fs();
        int c = fs_cnt;
        while (fs_cnt == c) @(negedge clk);
    endtask

    function automatic logic [31:0] scfg(int st, int ln, bit en, bit tx, bit msb, bit inv, bit two);
        return {16'(st), 2'b00, 6'(ln), 3'b000, two, inv, msb, tx, en};
    endfunction

    function automatic logic [31:0] gcfg(int bpf, bit tx, bit rx);
        return {14'b0, rx, tx, 16'(bpf)};
    endfunction

    task automatic exp_clear();
        for (int i = 0; i < 256; i++) expf[i] = 1'b1;
    endtask

    task automatic exp_place(int st, int ln, logic [31:0] w, bit msb, bit inv);
        for (int k = 0; k < ln; k++) expf[st+k] = (msb ? w[ln-1-k] : w[k]) ^ inv;
    endtask

    task automatic pat_place(int st, int ln, logic [31:0] w, bit msb, bit inv);
        for (int k = 0; k < ln; k++) din_pat[st+k] = (msb ? w[ln-1-k] : w[k]) ^ inv;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R12 dout in reset", tdm_dout, 1);
        check("R12 fs in reset", tdm_fs, 0);
        check("R12 clk in reset", tdm_clk, 0);
        check("R12 rx_word in reset", rx_word, 0);
        check("R12 rx_event in reset", rx_event, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_clock();
        wait_fs(); wait_fs(); wait_fs();
        check("R1 R12 default frame period", fs_per, 64*2*HALF);
        check("R1 bit clock high width", hi_w, HALF);
        check("R2 fs high one bit", fs_w, 2*HALF);
        check("R6 idle dout with tx disabled", tdm_dout, 1);
        wr(0, gcfg(48, 1, 0));
        wait_fs(); wait_fs(); wait_fs();
        check("R1 programmed frame period", fs_per, 48*2*HALF);
    endtask

    task automatic t_tx_basic();
        wr(1, scfg(4, 8, 1, 1, 1, 0, 0));
        wr(2, 32'h3C);
        wait_fs(); wait_fs();
        exp_clear(); exp_place(4, 8, 32'h3C, 1, 0);
        check_frame("R4 R6 MSB-first byte slot", 48);
    endtask

    task automatic t_boundary();
        wait_fs();
        repeat (6) @(negedge clk);
        wr(2, 32'hC3);
        wait_fs();
        exp_clear(); exp_place(4, 8, 32'h3C, 1, 0);
        check_frame("R11 mid-frame write deferred", 48);
        wait_fs();
        exp_clear(); exp_place(4, 8, 32'hC3, 1, 0);
        check_frame("R11 write applied next frame", 48);
    endtask

    task automatic t_tx_mix();
        wr(0, gcfg(64, 1, 0));
        wr(1, scfg(4, 8, 1, 1, 1, 0, 0));   wr(2, 32'h3C);
        wr(3, scfg(20, 12, 1, 1, 0, 1, 0)); wr(4, 32'h5A3);
        wr(5, scfg(0, 4, 1, 1, 1, 0, 0));   wr(6, 32'h9);
        wr(7, scfg(32, 32, 1, 1, 1, 0, 0)); wr(8, 32'hDEADBEEF);
        wait_fs(); wait_fs();
        exp_clear();
        exp_place(0, 4, 32'h9, 1, 0);
        exp_place(4, 8, 32'h3C, 1, 0);
        exp_place(20, 12, 32'h5A3, 0, 1);
        exp_place(32, 32, 32'hDEADBEEF, 1, 0);
        check_frame("R4 R5 R6 four slots incl. offset 0 and 32 bits", 64);
    endtask

    task automatic t_tx_disable();
        wr(0, gcfg(64, 0, 0));
        wait_fs(); wait_fs();
        exp_clear();
        check_frame("R6 transmit enable off gives all ones", 64);
    endtask

    task automatic t_rx();
        wr(1, scfg(8, 8, 1, 0, 1, 0, 0));
        wr(3, scfg(20, 12, 1, 0, 0, 1, 0));
        wr(0, gcfg(64, 1, 1));
        pat_place(8, 8, 32'hA5, 1, 0);
        pat_place(20, 12, 32'h2B7, 0, 1);
        wait_fs(); wait_fs();
        check("R3 R7 R8 slot0 MSB-first word", rx_word[31:0], 32'hA5);
        check("R5 R7 slot1 LSB-first inverted word", rx_word[63:32], 32'h2B7);
        check("R8 slot0 event on change", ev_cnt[0], 1);
        check("R8 slot1 event on change", ev_cnt[1], 1);
        wait_fs(); wait_fs();
        check("R8 repeated value raises no event", ev_cnt[0], 1);
        wait_fs();
        pat_place(8, 8, 32'h3E, 1, 0);
        wait_fs();
        check("R8 changed value word", rx_word[31:0], 32'h3E);
        check("R8 changed value event", ev_cnt[0], 2);
    endtask

    task automatic t_rx_two();
        wr(1, scfg(8, 8, 1, 0, 1, 0, 1));
        wait_fs();
        pat_place(8, 8, 32'h71, 1, 0);
        wait_fs();
        check("R9 first sighting not published", rx_word[31:0], 32'h3E);
        check("R9 first sighting no event", ev_cnt[0], 2);
        wait_fs();
        check("R9 second sighting published", rx_word[31:0], 32'h71);
        check("R9 second sighting event", ev_cnt[0], 3);
    endtask

    task automatic t_rx_off();
        wr(0, gcfg(64, 1, 0));
        wait_fs();
        pat_place(8, 8, 32'h0F, 1, 0);
        wait_fs(); wait_fs(); wait_fs();
        check("R10 receive disabled word held", rx_word[31:0], 32'h71);
        check("R10 receive disabled no event", ev_cnt[0], 3);
    endtask

    initial begin
        t_reset();
        t_clock();
        t_tx_basic();
        t_boundary();
        t_tx_mix();
        t_tx_disable();
        t_rx();
        t_rx_two();
        t_rx_off();
        summary();
        $finish;
    end

endmodule